// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Controller

This block is the digital front end of a two-channel, 10-bit voltage DAC. A host sends 16-bit command words over a three-wire serial port (active-low select, serial clock, data in). The block oversamples the port on its own system clock, shifts the word in, and acts on it when the select line goes high. Each channel has a two-stage register pair. The first stage is a holding (input) register. The second stage is the code that drives the converter. Because of this split, channels can be staged separately and then updated together.

A 3-bit leading field picks the operation. An all-zero field turns the upper four data bits into a sub-command. Sub-commands cover per-channel update, per-channel shutdown, a general-purpose output pin, and the edge on which the serial output changes. Shutdown is honoured only while the permit input is high. Pulling that input low wakes both channels, and they come back with the codes they held before. The serial output is the last stage of the shift register, so several devices can be daisy-chained. An asynchronous clear zeroes all holding and converter registers.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After rst_ni, both converter codes and both holding registers are zero, both shutdown flags are clear, both enables are high, user_o is low, and the serial output uses falling-edge mode.
- R2: A frame is 16 bits, sent MSB first, and sampled on rising SCLK while cs_ni is low. Bits [15:13] are the operation code, bits [12:3] are the 10-bit data, and bits [2:0] are ignored. A frame takes effect only after cs_ni rises.
- R3: Code 001 writes the data to holding A, and code 101 writes it to holding B. Neither code changes a converter code.
- R4: Code 010 writes holding A, and code 110 writes holding B. Both codes then copy both holding registers into both converter codes.
- R5: Code 011 writes the data into both holding registers and both converter codes.
- R6: Code 100 copies each holding register into its own converter code.
- R7: Code 111 shuts down both channels. With code 000, sub-command (bits [12:9]) 110x shuts down A and 111x shuts down B. Shutdown keeps all register contents. en_a_o and en_b_o are low while their channel is shut down.
- R8: While pd_allow_i is low, every shutdown command is ignored. A high-to-low transition of pd_allow_i clears both shutdown flags.
- R9: With code 000, sub-command 001x updates converter A from holding A, and 101x updates converter B from holding B. Any command that updates a channel's converter code clears that channel's shutdown flag.
- R10: With code 000, sub-command 010x drives user_o low and 011x drives it high. user_o changes at no other time.
- R11: With code 000, sub-command 1000 selects falling-edge mode and 1001 selects rising-edge mode. In falling-edge mode, dout_o takes the shift register MSB on each falling SCLK. In rising-edge mode, dout_o is the shift register MSB, so it changes on each rising SCLK.
- R12: A frame with any clock count other than 16 leaves all state unchanged.
- R13: A low on clr_ni asynchronously zeroes all holding registers and converter codes. It leaves the shutdown flags, user_o and the output mode unchanged.
- R14: Code 000 with sub-command 000x changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the SCLK rate |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| clr_ni | input | 1 | Asynchronous active-low register clear |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial data in |
| pd_allow_i | input | 1 | Shutdown permit; its falling edge wakes both channels |
| dout_o | output | 1 | Serial data out for daisy chaining |
| dac_a_o | output | 10 | Converter code, channel A |
| dac_b_o | output | 10 | Converter code, channel B |
| shdn_a_o | output | 1 | Channel A shut down |
| shdn_b_o | output | 1 | Channel B shut down |
| en_a_o | output | 1 | Channel A analog enable |
| en_b_o | output | 1 | Channel B analog enable |
| user_o | output | 1 | General-purpose logic output |

## Verification
The assertions assume that SCLK, cs_ni and pd_allow_i each stay at a level for at least two system clocks. Only then are the synchronised edges seen as single, clean events. They also assume that clr_ni is the only asynchronous input besides reset. The stimulus keeps every serial level for six system clocks. It changes data only while SCLK is low, and it raises cs_ni half an SCLK period after the last falling edge. It holds pd_allow_i and clr_ni for several clocks around each change, so no edge ever falls inside the synchroniser window.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int CODE_W = 3;
  localparam int SUB_W  = 3;
  localparam int SCMD_W = 4;
  localparam int NCH    = 2;

  typedef struct packed {
    logic [NCH-1:0] ld;
    logic [NCH-1:0] up;
    logic [NCH-1:0] sd;
    logic           upo_we;
    logic           upo_v;
    logic           mode_we;
    logic           mode_v;
  } act_t;
endpackage

// File: rtl/dac_bit_sync.sv
module dac_bit_sync #(
  parameter int   N       = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [N-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {N{RST_VAL}};
    else         ff_q <= {ff_q[N-2:0], d_i};
  end

  assign q_o = ff_q[N-1];
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
  parameter int WORD_W = 16,
  parameter int SUB_W  = 3,
  parameter int CNT_W  = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_n_i,
  input  logic                    sclk_i,
  input  logic                    din_i,
  input  logic                    mode1_i,
  output logic                    frame_vld_o,
  output logic                    cs_rise_o,
  output logic [CNT_W-1:0]        bit_cnt_o,
  output logic [WORD_W-1:SUB_W]   payload_o,
  output logic                    dout_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(WORD_W + 1);

  logic              sclk_d, cs_d, dout_q;
  logic              sclk_rise, sclk_fall;
  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_i;
      cs_d   <= cs_n_i;
    end
  end

  assign sclk_rise = sclk_i & ~sclk_d;
  assign sclk_fall = ~sclk_i & sclk_d;
  assign cs_rise_o = cs_n_i & ~cs_d;

  // count saturates one past a full word so long frames are rejected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (cs_n_i) begin
      cnt_q <= '0;
    end else if (sclk_rise) begin
      sr_q <= {sr_q[WORD_W-2:0], din_i};
      if (cnt_q != SAT) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  dout_q <= 1'b0;
    else if (!cs_n_i && sclk_fall) dout_q <= sr_q[WORD_W-1];
  end

  assign frame_vld_o = cs_rise_o && (cnt_q == FULL);
  assign bit_cnt_o   = cnt_q;
  assign payload_o   = sr_q[WORD_W-1:SUB_W];
  assign dout_o      = mode1_i ? sr_q[WORD_W-1] : dout_q;
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_ctrl_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic [SCMD_W-1:0] sub_i,
  input  logic              pd_allow_i,
  output act_t              act_o
);
  always_comb begin
    act_o = '0;
    unique case (code_i)
      3'b001: act_o.ld = 2'b01;
      3'b101: act_o.ld = 2'b10;
      3'b010: begin act_o.ld = 2'b01; act_o.up = 2'b11; end
      3'b110: begin act_o.ld = 2'b10; act_o.up = 2'b11; end
      3'b011: begin act_o.ld = 2'b11; act_o.up = 2'b11; end
      3'b100: act_o.up = 2'b11;
      3'b111: act_o.sd = {2{pd_allow_i}};
      default: begin
        unique case (sub_i[SCMD_W-1:1])
          3'b001: act_o.up = 2'b01;
          3'b101: act_o.up = 2'b10;
          3'b110: act_o.sd = {1'b0, pd_allow_i};
          3'b111: act_o.sd = {pd_allow_i, 1'b0};
          3'b010: begin act_o.upo_we = 1'b1; act_o.upo_v = 1'b0; end
          3'b011: begin act_o.upo_we = 1'b1; act_o.upo_v = 1'b1; end
          3'b100: begin act_o.mode_we = 1'b1; act_o.mode_v = sub_i[0]; end
          default: ;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_ctrl_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         data_rst_ni,
  input  logic                         vld_i,
  input  act_t                         act_i,
  input  logic [DATA_W-1:0]            data_i,
  input  logic                         pdl_i,
  output logic [NCH-1:0][DATA_W-1:0]   dac_o,
  output logic [NCH-1:0]               sd_o,
  output logic                         upo_o,
  output logic                         mode1_o
);
  logic pdl_d, pdl_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pdl_d <= 1'b1;
    else         pdl_d <= pdl_i;
  end
  assign pdl_fall = pdl_d & ~pdl_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DATA_W-1:0] in_q, in_nxt, dac_q;
    logic              sd_q;

    assign in_nxt = (vld_i && act_i.ld[ch]) ? data_i : in_q;

    always_ff @(posedge clk_i or negedge data_rst_ni) begin
      if (!data_rst_ni) begin
        in_q  <= '0;
        dac_q <= '0;
      end else begin
        in_q <= in_nxt;
        if (vld_i && act_i.up[ch]) dac_q <= in_nxt;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    sd_q <= 1'b0;
      else if (vld_i && act_i.up[ch]) sd_q <= 1'b0;
      else if (vld_i && act_i.sd[ch]) sd_q <= 1'b1;
      else if (pdl_fall)              sd_q <= 1'b0;
    end

    assign dac_o[ch] = dac_q;
    assign sd_o[ch]  = sd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upo_o   <= 1'b0;
      mode1_o <= 1'b0;
    end else if (vld_i) begin
      if (act_i.upo_we)  upo_o   <= act_i.upo_v;
      if (act_i.mode_we) mode1_o <= act_i.mode_v;
    end
  end
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              pd_allow_i,
  output logic              dout_o,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o,
  output logic              shdn_a_o,
  output logic              shdn_b_o,
  output logic              en_a_o,
  output logic              en_b_o,
  output logic              user_o
);
  localparam int WORD_W = CODE_W + DATA_W + SUB_W;
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam int NSYNC  = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1001;  // {pdl, din, sclk, cs}

  logic [NSYNC-1:0] raw, syn;
  logic cs_s, sclk_s, din_s, pdl_s;
  logic arst_n, clr_n_q, data_rst_n;
  logic frame_vld, cs_rise, mode1;
  logic [CNT_W-1:0] bit_cnt;
  logic [WORD_W-1:SUB_W] payload;
  logic [CODE_W-1:0] cmd_code;
  logic [DATA_W-1:0] cmd_data;
  act_t act;
  logic [NCH-1:0][DATA_W-1:0] dac_w;
  logic [NCH-1:0] sd_w;

  assign raw = {pd_allow_i, din_i, sclk_i, cs_ni};
  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    dac_bit_sync #(.N(SYNC_N), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw[g]), .q_o(syn[g])
    );
  end
  assign {pdl_s, din_s, sclk_s, cs_s} = syn;

  // clear: asynchronous assert, synchronous release
  assign arst_n = rst_ni & clr_ni;
  dac_bit_sync #(.N(SYNC_N), .RST_VAL(1'b0)) u_clr_sync (
    .clk_i(clk_i), .rst_ni(arst_n), .d_i(1'b1), .q_o(clr_n_q)
  );
  assign data_rst_n = rst_ni & clr_n_q;

  dac_serial_rx #(.WORD_W(WORD_W), .SUB_W(SUB_W), .CNT_W(CNT_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_s), .sclk_i(sclk_s),
    .din_i(din_s), .mode1_i(mode1), .frame_vld_o(frame_vld),
    .cs_rise_o(cs_rise), .bit_cnt_o(bit_cnt), .payload_o(payload),
    .dout_o(dout_o)
  );

  assign cmd_code = payload[WORD_W-1 -: CODE_W];
  assign cmd_data = payload[WORD_W-CODE_W-1 -: DATA_W];

  dac_cmd_decode u_dec (
    .code_i(cmd_code), .sub_i(cmd_data[DATA_W-1 -: SCMD_W]),
    .pd_allow_i(pdl_s), .act_o(act)
  );

  dac_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_rst_ni(data_rst_n),
    .vld_i(frame_vld), .act_i(act), .data_i(cmd_data), .pdl_i(pdl_s),
    .dac_o(dac_w), .sd_o(sd_w), .upo_o(user_o), .mode1_o(mode1)
  );

  assign dac_a_o  = dac_w[0];
  assign dac_b_o  = dac_w[1];
  assign shdn_a_o = sd_w[0];
  assign shdn_b_o = sd_w[1];
  assign en_a_o   = ~sd_w[0];
  assign en_b_o   = ~sd_w[1];
endmodule

// File: rtl/dac_ctrl_chk.sv
module dac_ctrl_chk #(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_n_q,
  input logic              frame_vld,
  input logic              cs_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              pdl_s,
  input logic [2:0]        cmd_code,
  input logic [DATA_W-1:0] dac_a_o,
  input logic [DATA_W-1:0] dac_b_o,
  input logic              shdn_a_o,
  input logic              shdn_b_o,
  input logic              user_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W + 6);

  assert_dac_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_vld && clr_n_q) |=> (($stable(dac_a_o) && $stable(dac_b_o)) || !clr_n_q));

  assert_bad_frame_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && bit_cnt != FULL && clr_n_q) |=>
      (($stable(dac_a_o) && $stable(dac_b_o) && $stable(shdn_a_o) && $stable(shdn_b_o)
        && $stable(user_o)) || !clr_n_q));

  assert_lockout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && !pdl_s) |=> (!$rose(shdn_a_o) && !$rose(shdn_b_o)));

  assert_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pdl_s) |=> (!shdn_a_o && !shdn_b_o));

  assert_update_wakes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && cmd_code == 3'b100) |=> (!shdn_a_o && !shdn_b_o));

  assert_user_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld |=> $stable(user_o));

  assert_clear_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_n_q |-> (dac_a_o == '0 && dac_b_o == '0));
endmodule

bind dual_dac_ctrl dac_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_n_q(clr_n_q), .frame_vld(frame_vld),
  .cs_rise(cs_rise), .bit_cnt(bit_cnt), .pdl_s(pdl_s), .cmd_code(cmd_code),
  .dac_a_o(dac_a_o), .dac_b_o(dac_b_o), .shdn_a_o(shdn_a_o),
  .shdn_b_o(shdn_b_o), .user_o(user_o)
);

// File: tb/dual_dac_ctrl_test.sv
`timescale 1ns/1ps
module dual_dac_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, clr_n = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, pd_allow = 1'b1;
  logic dout, sh_a, sh_b, en_a, en_b, usr;
  logic [9:0] dac_a, dac_b;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_dac_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .cs_ni(cs_n), .sclk_i(sclk),
    .din_i(din), .pd_allow_i(pd_allow), .dout_o(dout), .dac_a_o(dac_a),
    .dac_b_o(dac_b), .shdn_a_o(sh_a), .shdn_b_o(sh_b), .en_a_o(en_a),
    .en_b_o(en_b), .user_o(usr)
  );

  function automatic logic [15:0] mk(input logic [2:0] c, input logic [9:0] d);
    return {c, d, 3'b000};
  endfunction
  function automatic logic [15:0] sub(input logic [3:0] s);
    return {3'b000, s, 9'b0};
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one frame; obs collects dout sampled late in each high phase, bits 1..15
  task automatic frame(input logic [15:0] w, input int nbits, output logic [14:0] obs);
    obs = '0;
    cs_n = 1'b0; wclk(6);
    for (int i = 0; i < nbits; i++) begin
      din = (i < 16) ? w[15-i] : 1'b0;
      wclk(6); sclk = 1'b1; wclk(6);
      if (i < 15) obs[14-i] = dout;
      sclk = 1'b0;
    end
    wclk(6); cs_n = 1'b1; wclk(8);
  endtask

  task automatic send(input logic [15:0] w);
    logic [14:0] o;
    frame(w, 16, o);
  endtask

  task automatic t_reset;
    chk("R1 dac_a", dac_a, 0); chk("R1 dac_b", dac_b, 0);
    chk("R1 shdn", {sh_a, sh_b}, 0); chk("R1 en", {en_a, en_b}, 2'b11);
    chk("R1 user", usr, 0);
    send(mk(3'b100, 10'h3FF));
    chk("R1 holding zero", {dac_a, dac_b}, 0);
  endtask

  task automatic t_loads;
    send(mk(3'b001, 10'h155));
    chk("R3 load A no update", {dac_a, dac_b}, 0);
    send(mk(3'b101, 10'h2AA));
    chk("R3 load B no update", {dac_a, dac_b}, 0);
    send(mk(3'b100, 10'h000));
    chk("R6 update both", {dac_a, dac_b}, {10'h155, 10'h2AA});
    chk("R2 field order", dac_a, 10'h155);
    send(mk(3'b010, 10'h0F0));
    chk("R4 load A update all", {dac_a, dac_b}, {10'h0F0, 10'h2AA});
    send(mk(3'b110, 10'h333));
    chk("R4 load B update all", {dac_a, dac_b}, {10'h0F0, 10'h333});
    send(mk(3'b011, 10'h3FF));
    chk("R5 direct both", {dac_a, dac_b}, {10'h3FF, 10'h3FF});
    send(mk(3'b100, 10'h000));
    chk("R5 holding also written", {dac_a, dac_b}, {10'h3FF, 10'h3FF});
  endtask

  task automatic t_shutdown;
    send(sub(4'b1100));
    chk("R7 shut A", {sh_a, sh_b, en_a, en_b}, 4'b1001);
    chk("R7 code kept", dac_a, 10'h3FF);
    send(sub(4'b1110));
    chk("R7 shut B", {sh_a, sh_b, en_a, en_b}, 4'b1100);
    send(mk(3'b101, 10'h011));
    chk("R7 load keeps shutdown", {sh_a, sh_b, dac_b}, {2'b11, 10'h3FF});
    send(sub(4'b0010));
    chk("R9 update A wakes A", {sh_a, sh_b, dac_a}, {2'b01, 10'h3FF});
    send(sub(4'b1010));
    chk("R9 update B wakes B", {sh_a, sh_b, dac_b}, {2'b00, 10'h011});
    send(mk(3'b111, 10'h0));
    chk("R7 shut both", {sh_a, sh_b}, 2'b11);
    send(mk(3'b100, 10'h0));
    chk("R9 update both wakes", {sh_a, sh_b, dac_a, dac_b}, {2'b00, 10'h3FF, 10'h011});
  endtask

  task automatic t_lockout;
    send(mk(3'b111, 10'h0));
    chk("R8 shut permitted", {sh_a, sh_b}, 2'b11);
    pd_allow = 1'b0; wclk(8);
    chk("R8 falling permit wakes", {sh_a, sh_b, dac_a, dac_b}, {2'b00, 10'h3FF, 10'h011});
    send(mk(3'b111, 10'h0));
    chk("R8 both ignored", {sh_a, sh_b}, 2'b00);
    send(sub(4'b1100));
    chk("R8 A ignored", {sh_a, sh_b}, 2'b00);
    pd_allow = 1'b1; wclk(8);
  endtask

  task automatic t_user_nop;
    logic [22:0] snap;
    send(sub(4'b0110));
    chk("R10 user high", usr, 1'b1);
    send(sub(4'b0100));
    chk("R10 user low", usr, 1'b0);
    send(sub(4'b0111));
    chk("R10 user high again", usr, 1'b1);
    snap = {usr, sh_b, sh_a, dac_b, dac_a};
    send(16'h01FF);
    chk("R14 nop", {usr, sh_b, sh_a, dac_b, dac_a}, snap);
  endtask

  task automatic t_bad_frames;
    logic [14:0] o;
    logic [22:0] snap;
    snap = {usr, sh_b, sh_a, dac_b, dac_a};
    frame(mk(3'b011, 10'h001), 15, o);
    chk("R12 short frame", {usr, sh_b, sh_a, dac_b, dac_a}, snap);
    frame(mk(3'b011, 10'h001), 17, o);
    chk("R12 long frame", {usr, sh_b, sh_a, dac_b, dac_a}, snap);
    frame(mk(3'b111, 10'h0), 17, o);
    chk("R12 long shutdown", {sh_a, sh_b}, 2'b00);
  endtask

  task automatic t_dout;
    logic [14:0] o;
    send(16'h03A5);
    frame(16'h0000, 16, o);
    chk("R11 falling-edge mode stream", o, 15'(16'h03A5 >> 1));
    send(sub(4'b1001));
    send(16'h02C7);
    frame(16'h0000, 16, o);
    chk("R11 rising-edge mode stream", o, 15'(16'h02C7));
    send(sub(4'b1000));
    send(16'h0255);
    frame(16'h0000, 16, o);
    chk("R11 back to falling-edge", o, 15'(16'h0255 >> 1));
  endtask

  task automatic t_clear;
    send(mk(3'b011, 10'h2A5));
    send(mk(3'b111, 10'h0));
    clr_n = 1'b0; wclk(4);
    chk("R13 clear zeroes codes", {dac_a, dac_b}, 0);
    clr_n = 1'b1; wclk(6);
    chk("R13 other state kept", {usr, sh_a, sh_b}, 3'b111);
    send(mk(3'b100, 10'h0));
    chk("R13 holding cleared", {dac_a, dac_b, sh_a, sh_b}, 0);
  endtask

  initial begin
    wclk(200000 - 100);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wclk(5); rst_n = 1'b1; wclk(5);
    t_reset;
    t_loads;
    t_shutdown;
    t_lockout;
    t_user_nop;
    t_bad_frames;
    t_dout;
    t_clear;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule